// File: doc/BRIEF.md
# Broadcast/Serial Scan Chain Wrapper with Output Signature Compaction

This block holds the scan flip-flops of a full-scan design as NCH internal chains of LEN cells each, all fed from one scan-in pin. In broadcast mode the same serial bit lands in the first cell of every chain on each shift cycle. A full load then takes LEN cycles instead of NCH×LEN, and the stored stimulus shrinks by the same factor. Some stimuli need different values in cells that broadcast would force equal. For those, serial mode links the chains end to end into a single NCH×LEN path, so any pattern can be loaded.

When scan enable is low, every cell loads its bit from the capture bus in parallel. The tail cell of each chain feeds one stage of a multiple-input signature register. The register compacts the chain outputs on every shift cycle. After a test it can be cleared, or shifted out one bit per cycle through the scan-out pin.

Top module: `scan_fanout_wrapper`

## Requirements
- R1: While rst_n is low, every chain cell and every signature bit is 0, so chain_out, signature and scan_out all read 0.
- R2: With scan_en high and serial_mode low, cell 0 of every chain takes scan_in on each clock and cell j takes cell j-1. After LEN such cycles, all chains hold the same last LEN bits of the stream.
- R3: With scan_en high and serial_mode high, cell 0 of chain 0 takes scan_in and cell 0 of chain i (i>0) takes the tail cell LEN-1 of chain i-1. A bit therefore reaches chain_out[NCH-1] after NCH×LEN shifts.
- R4: With scan_en low, cell j of chain i loads cap_data[i*LEN+j] on the clock edge. chain_out[i] is cell LEN-1 of chain i.
- R5: On a shift cycle with sig_clear and sig_read low, the signature S becomes ({S[NCH-2:0],0} XOR (S[NCH-1] ? P : 0) XOR T). T is the chain_out value before the edge. For NCH=4, P = 4'b0011, the mask of x^4+x+1.
- R6: With scan_en, sig_clear and sig_read all low, the signature holds its value.
- R7: sig_clear high sets the signature to 0 on the next edge. This overrides sig_read and compaction.
- R8: With sig_read high and sig_clear low, the signature shifts toward its MSB, taking in 0, and takes in no chain data. scan_out always shows signature[NCH-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan/test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | 1: shift chains; 0: parallel capture |
| serial_mode | input | 1 | 0: broadcast to all chains; 1: chains concatenated |
| scan_in | input | 1 | Single serial scan-in pin |
| cap_data | input | NCH*LEN | Capture response, bit i*LEN+j goes to chain i cell j |
| sig_clear | input | 1 | Synchronous signature clear |
| sig_read | input | 1 | Shift signature out on scan_out |
| chain_out | output | NCH | Tail cell of each chain |
| signature | output | NCH | Compactor contents |
| scan_out | output | 1 | Serial signature bit (MSB) |

## Verification
Two different broadcast streams are driven. Every chain output must match each other and the stream delayed by LEN, which separates a true fan-out from a chain fed from the wrong source. A 32-bit serial stream shows whether the links between chains run in the right order and whether a load takes the full NCH×LEN delay. An asymmetric capture word followed by unloading checks the mapping of each bit into its cell. The same unloading feeds the signature, so the feedback polynomial and the input stages are checked as well. Read-out, clear-during-read and hold cycles each separate one control priority from the others.

// File: rtl/scan_fanout_wrapper.sv
module scan_fanout_wrapper #(
  parameter int NCH = 4,
  parameter int LEN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               serial_mode,
  input  logic               scan_in,
  input  logic [NCH*LEN-1:0] cap_data,
  input  logic               sig_clear,
  input  logic               sig_read,
  output logic [NCH-1:0]     chain_out,
  output logic [NCH-1:0]     signature,
  output logic               scan_out
);

  // Galois feedback masks of primitive polynomials, x^n term omitted
  function automatic logic [15:0] poly_mask(input int n);
    case (n)
      2:       return 16'h0003;
      3:       return 16'h0003;
      4:       return 16'h0003;
      5:       return 16'h0005;
      6:       return 16'h0003;
      7:       return 16'h0003;
      8:       return 16'h0071;
      16:      return 16'h6801;
      default: return 16'h0003;
    endcase
  endfunction

  localparam logic [15:0]    POLY16 = poly_mask(NCH);
  localparam logic [NCH-1:0] POLY   = POLY16[NCH-1:0];

  logic [LEN-1:0] cells [NCH];
  logic [NCH-1:0] feed;
  logic [NCH-1:0] misr_next;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chain
      if (i == 0) begin : g_head
        assign feed[i] = scan_in;
      end else begin : g_link
        assign feed[i] = serial_mode ? cells[i-1][LEN-1] : scan_in;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cells[i] <= '0;
        else if (scan_en) cells[i] <= {cells[i][LEN-2:0], feed[i]};
        else              cells[i] <= cap_data[i*LEN +: LEN];
      end

      assign chain_out[i] = cells[i][LEN-1];

      p_bcast_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !serial_mode) |=> (cells[i][0] == $past(scan_in)));

      p_capture_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (chain_out[i] == $past(cap_data[i*LEN+LEN-1])));

      if (i > 0) begin : g_serial_chk
        p_serial_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (scan_en && serial_mode) |=> (cells[i][0] == $past(chain_out[i-1])));
      end
    end
  endgenerate

  assign misr_next = {signature[NCH-2:0], 1'b0}
                   ^ (signature[NCH-1] ? POLY : '0)
                   ^ chain_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         signature <= '0;
    else if (sig_clear) signature <= '0;
    else if (sig_read)  signature <= {signature[NCH-2:0], 1'b0};
    else if (scan_en)   signature <= misr_next;
  end

  assign scan_out = signature[NCH-1];

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sig_clear |=> (signature == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !sig_clear && !sig_read) |=> $stable(signature));

  p_read_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_read && !sig_clear) |=> (signature == {$past(signature[NCH-2:0]), 1'b0}));

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (signature == '0 && chain_out == '0));

endmodule

// File: tb/scan_fanout_wrapper_test.sv
module scan_fanout_wrapper_test;
  localparam int NCH = 4;
  localparam int LEN = 8;
  localparam logic [NCH-1:0] POLY = 4'b0011;

  logic clk = 0, rst_n = 0;
  logic scan_en = 0, serial_mode = 0, scan_in = 0, sig_clear = 0, sig_read = 0;
  logic [NCH*LEN-1:0] cap_data = '0;
  logic [NCH-1:0] chain_out, signature;
  logic scan_out;

  scan_fanout_wrapper #(.NCH(NCH), .LEN(LEN)) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .serial_mode(serial_mode),
    .scan_in(scan_in), .cap_data(cap_data), .sig_clear(sig_clear),
    .sig_read(sig_read), .chain_out(chain_out), .signature(signature),
    .scan_out(scan_out));

  always #2 clk = ~clk;

  typedef struct {
    logic [NCH-1:0] tails;
    logic [NCH-1:0] sig;
    logic           so;
    string          req;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;
  logic [LEN-1:0] m [NCH];
  logic [NCH-1:0] ms;

  task automatic check(input string req, input logic [NCH-1:0] act_t, input logic [NCH-1:0] act_s,
                       input logic act_o, input exp_t e);
    tests++;
    if (act_t !== e.tails || act_s !== e.sig || act_o !== e.so) begin
      fails++;
      $display("FAIL %s: chain_out=%b signature=%b scan_out=%b expected %b %b %b",
               req, act_t, act_s, act_o, e.tails, e.sig, e.so);
    end
  endtask

  task automatic step(input logic se, input logic sm, input logic si,
                      input logic [NCH*LEN-1:0] cap, input logic clr,
                      input logic rd, input string req);
    logic [NCH-1:0] old_t;
    exp_t e;
    @(negedge clk);
    scan_en = se; serial_mode = sm; scan_in = si; cap_data = cap;
    sig_clear = clr; sig_read = rd;
    for (int i = 0; i < NCH; i++) old_t[i] = m[i][LEN-1];
    for (int i = 0; i < NCH; i++) begin
      if (se) m[i] = {m[i][LEN-2:0], (sm && i > 0) ? old_t[i-1] : si};
      else    m[i] = cap[i*LEN +: LEN];
    end
    if (clr)     ms = '0;
    else if (rd) ms = {ms[NCH-2:0], 1'b0};
    else if (se) ms = {ms[NCH-2:0], 1'b0} ^ (ms[NCH-1] ? POLY : '0) ^ old_t;
    for (int i = 0; i < NCH; i++) e.tails[i] = m[i][LEN-1];
    e.sig = ms; e.so = ms[NCH-1]; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare one item per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, chain_out, signature, scan_out, e);
      end
    end
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] bpat;
    logic [31:0] spat;
    exp_t z;
    for (int i = 0; i < NCH; i++) m[i] = '0;
    ms = '0;
    #7;
    z.tails = '0; z.sig = '0; z.so = 0; z.req = "R1";
    check("R1 reset state", chain_out, signature, scan_out, z);
    @(negedge clk); rst_n = 1;

    step(0, 0, 0, '0, 1, 0, "R7 clear");
    bpat = 16'b1011_0010_0110_1101;
    for (int k = 0; k < 16; k++) step(1, 0, bpat[k], '0, 0, 0, "R2 broadcast/R5 misr");
    spat = 32'hC39A_5E17;
    for (int k = 0; k < 32; k++) step(1, 1, spat[k], '0, 0, 0, "R3 serial/R5 misr");
    step(0, 0, 0, 32'hA5C3_1E96, 0, 0, "R4 capture/R6 hold");
    step(0, 0, 0, 32'h0F0F_8421, 0, 0, "R4 capture/R6 hold");
    for (int k = 0; k < LEN; k++) step(1, 0, 1'b0, '0, 0, 0, "R4 unload/R5 misr");
    for (int k = 0; k < NCH; k++) step(0, 0, 0, 32'hFFFF_0000, 0, 1, "R8 read out");
    step(0, 0, 0, 32'h1234_5678, 0, 0, "R4 capture");
    for (int k = 0; k < 3; k++) step(1, 0, 1'b1, '0, 0, 0, "R5 misr");
    step(1, 0, 1'b1, '0, 0, 1, "R8 read no compaction");
    step(1, 1, 1'b1, '0, 1, 1, "R7 clear over read");
    for (int k = 0; k < 4; k++) step(1, 1, k[0], '0, 0, 0, "R3 serial/R5 misr");
    @(negedge clk); scan_en = 0; sig_read = 0; sig_clear = 0;
    @(posedge clk); #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule